// File: doc/BRIEF.md
# Exception Vector Fetch Sequencer

This block turns a reset, an exception or an interrupt into the handler address that the processor jumps to. When reset is released it reads two longwords from fixed low addresses: first the initial stack pointer, then the initial program counter. After that, each accepted request is turned into a vector number. That number, times four, is added to a writable vector base register, and the longword at the resulting address is read as the handler address.

Memory is reached through a simple synchronous read port. The port has an address, a read strobe, 16-bit read data and a ready input. Each longword takes two reads, high word first. Results appear on the outputs together with a one-cycle completion pulse.

Requests are level signals. They are sampled only while the sequencer is idle, so a requester holds its request until it sees the completion pulse for it. Executing instructions, saving processor state and bus arbitration happen elsewhere.

Top module: `vecfetch_seq`

## Requirements
- R1: After reset is released, the block at once reads the longword at address 0 and loads it into `init_sp`. It then reads the longword at address 4 and presents it on `new_pc` with `done` high, `boot_flag` 1 and `svc_vec` 0.
- R2: Every longword is fetched as two 16-bit reads at even addresses. The first read is at the longword address and supplies bits 31:16. The second read is at that address plus 2 and supplies bits 15:0.
- R3: While `mem_rd` is high and `mem_rdy` is low, the read strobe stays high and `mem_addr` stays unchanged in the next cycle. A word is taken only in a cycle where `mem_rdy` is high.
- R4: For a vector number V, the handler longword is read at (vector base + 4*V), using 32-bit wrap-around addition.
- R5: The vector base register resets to 0. A write with `vbr_we` high stores `vbr_wdata` with bits 1:0 forced to 0. A request accepted in the same cycle as a write still uses the old base; requests accepted later use the new one.
- R6: When several requests are present in one idle cycle, they are served in this order: bus error (vector 2), then address error (vector 3), then the general exception request (vector `exc_vec`), then the interrupt request.
- R7: With `irq_auto` high, an interrupt uses vector 24 + `irq_level`. Levels 1 to 7 give vectors 25 to 31, and level 0 gives the spurious vector 24. With `irq_auto` low, the interrupt uses `irq_vec`.
- R8: `done` is a one-cycle pulse. It rises in the cycle after the ready of the second word. In that cycle `new_pc`, `svc_vec` and `boot_flag` are valid, and `mem_rd` is low. For a vector fetch, `boot_flag` is 0 and `svc_vec` is the vector number.
- R9: Requests that arrive while a fetch is in progress have no effect on that fetch. A request still held when the fetch ends is served next.
- R10: Only the reset sequence changes `init_sp`; vector fetches leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts the reset sequence |
| vbr_we | input | 1 | Write enable for the vector base register |
| vbr_wdata | input | 32 | New vector base (bits 1:0 ignored) |
| berr_req | input | 1 | Bus error request (vector 2) |
| aerr_req | input | 1 | Address error request (vector 3) |
| exc_req | input | 1 | General exception request |
| exc_vec | input | 8 | Vector number for the general exception request |
| irq_req | input | 1 | Interrupt request |
| irq_level | input | 3 | Interrupt level used for autovectoring |
| irq_auto | input | 1 | 1: autovector from level; 0: use `irq_vec` |
| irq_vec | input | 8 | Vector number supplied by the interrupting device |
| mem_addr | output | 32 | Byte address of the current 16-bit read |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_rdata | input | 16 | Read data |
| mem_rdy | input | 1 | Read data valid this cycle |
| init_sp | output | 32 | Initial stack pointer from the reset sequence |
| new_pc | output | 32 | Initial program counter or handler address |
| done | output | 1 | One-cycle completion pulse |
| boot_flag | output | 1 | 1 when the completed fetch was the reset sequence |
| svc_vec | output | 8 | Vector number of the completed fetch |

## Verification
The bench stretches reads with ready delays of up to three cycles. A design that latched data without waiting for ready, or moved its address early, would show a wrong longword or a wrong address. It raises requests of several kinds at once to expose a swapped priority, which would show up as the wrong vector number. It writes base values with low bits set, and writes a base in the same cycle as a request, to catch a misaligned table or a base that takes effect one cycle too early. It also raises a bus error in the middle of a fetch and reapplies reset partway through a fetch, to catch a design that restarts on a new request or keeps a stale base after reset.

// File: rtl/vf_pkg.sv
package vf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2
    } seq_st_e;

    localparam logic [7:0] VEC_BUS_ERR  = 8'd2;
    localparam logic [7:0] VEC_ADDR_ERR = 8'd3;
    localparam logic [7:0] VEC_SPURIOUS = 8'd24;

endpackage

// File: rtl/vf_vbr.sv
module vf_vbr #(
    parameter int W     = 32,
    parameter int ALIGN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] base
);
    logic [W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (we) base_d = {wdata[W-1:ALIGN], {ALIGN{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign base = base_q;
endmodule

// File: rtl/vf_arb.sv
module vf_arb
    import vf_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             berr_req,
    input  logic             aerr_req,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_vec,
    input  logic             irq_req,
    input  logic [2:0]       irq_level,
    input  logic             irq_auto,
    input  logic [VEC_W-1:0] irq_vec,
    output logic             grant,
    output logic [VEC_W-1:0] grant_vec
);
    logic [VEC_W-1:0] irq_num;

    always_comb begin
        if (irq_auto) irq_num = VEC_W'(VEC_SPURIOUS) + VEC_W'(irq_level);
        else          irq_num = irq_vec;
    end

    always_comb begin
        grant     = 1'b1;
        grant_vec = '0;
        if (berr_req)      grant_vec = VEC_W'(VEC_BUS_ERR);
        else if (aerr_req) grant_vec = VEC_W'(VEC_ADDR_ERR);
        else if (exc_req)  grant_vec = exc_vec;
        else if (irq_req)  grant_vec = irq_num;
        else               grant     = 1'b0;
    end
endmodule

// File: rtl/vecfetch_seq.sv
module vecfetch_seq
    import vf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 16,
    parameter int VEC_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vbr_we,
    input  logic [ADDR_W-1:0]    vbr_wdata,
    input  logic                 berr_req,
    input  logic                 aerr_req,
    input  logic                 exc_req,
    input  logic [VEC_W-1:0]     exc_vec,
    input  logic                 irq_req,
    input  logic [2:0]           irq_level,
    input  logic                 irq_auto,
    input  logic [VEC_W-1:0]     irq_vec,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_rd,
    input  logic [BUS_W-1:0]     mem_rdata,
    input  logic                 mem_rdy,
    output logic [2*BUS_W-1:0]   init_sp,
    output logic [2*BUS_W-1:0]   new_pc,
    output logic                 done,
    output logic                 boot_flag,
    output logic [VEC_W-1:0]     svc_vec
);
    localparam int LONG_W     = 2 * BUS_W;
    localparam int STEP_BYTES = BUS_W / 8;
    localparam int LONG_BYTES = LONG_W / 8;
    localparam int IDX_SH     = $clog2(LONG_BYTES);
    localparam logic [ADDR_W-1:0] SP_ADDR = '0;
    localparam logic [ADDR_W-1:0] PC_ADDR = ADDR_W'(LONG_BYTES);

    typedef struct packed {
        seq_st_e            st;
        logic [ADDR_W-1:0]  addr;
        logic [BUS_W-1:0]   hi;
        logic               boot;
        logic               stage;
        logic [LONG_W-1:0]  sp;
        logic [LONG_W-1:0]  pc;
        logic [VEC_W-1:0]   vec;
        logic               done;
    } seq_t;

    seq_t r_d, r_q;

    logic [ADDR_W-1:0] vbr_q;
    logic              arb_grant;
    logic [VEC_W-1:0]  arb_vec;

    vf_vbr #(.W(ADDR_W), .ALIGN(IDX_SH)) u_vbr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (vbr_we),
        .wdata (vbr_wdata),
        .base  (vbr_q)
    );

    vf_arb #(.VEC_W(VEC_W)) u_arb (
        .berr_req  (berr_req),
        .aerr_req  (aerr_req),
        .exc_req   (exc_req),
        .exc_vec   (exc_vec),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .irq_auto  (irq_auto),
        .irq_vec   (irq_vec),
        .grant     (arb_grant),
        .grant_vec (arb_vec)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (arb_grant) begin
                    r_d.st    = ST_HI;
                    r_d.addr  = vbr_q + (ADDR_W'(arb_vec) << IDX_SH);
                    r_d.boot  = 1'b0;
                    r_d.stage = 1'b0;
                    r_d.vec   = arb_vec;
                end
            end
            ST_HI: begin
                if (mem_rdy) begin
                    r_d.hi   = mem_rdata;
                    r_d.addr = r_q.addr + ADDR_W'(STEP_BYTES);
                    r_d.st   = ST_LO;
                end
            end
            ST_LO: begin
                if (mem_rdy) begin
                    if (r_q.boot && !r_q.stage) begin
                        r_d.sp    = {r_q.hi, mem_rdata};
                        r_d.stage = 1'b1;
                        r_d.addr  = PC_ADDR;
                        r_d.st    = ST_HI;
                    end else begin
                        r_d.pc   = {r_q.hi, mem_rdata};
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_HI;
            r_q.addr  <= SP_ADDR;
            r_q.boot  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.addr;
    assign mem_rd    = (r_q.st != ST_IDLE);
    assign init_sp   = r_q.sp;
    assign new_pc    = r_q.pc;
    assign done      = r_q.done;
    assign boot_flag = r_q.boot;
    assign svc_vec   = r_q.vec;
endmodule

// File: rtl/vf_check.sv
module vf_check #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_rdy,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done
);
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr))); // R3

    AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[0] == 1'b0)); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd && mem_rdy)); // R8

    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd); // R8
endmodule

bind vecfetch_seq vf_check #(.ADDR_W(ADDR_W)) u_vf_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_rdy  (mem_rdy),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/vecfetch_seq_test.sv
`timescale 1ns/1ps
module vecfetch_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vbr_we = 1'b0;
    logic [31:0] vbr_wdata = '0;
    logic        berr_req = 1'b0, aerr_req = 1'b0, exc_req = 1'b0, irq_req = 1'b0;
    logic [7:0]  exc_vec = '0, irq_vec = '0;
    logic [2:0]  irq_level = '0;
    logic        irq_auto = 1'b0;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic [15:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic [31:0] init_sp, new_pc;
    logic        done, boot_flag;
    logic [7:0]  svc_vec;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] boot_sp;

    always #5 clk = ~clk;

    vecfetch_seq uut (
        .clk(clk), .rst_n(rst_n), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
        .berr_req(berr_req), .aerr_req(aerr_req), .exc_req(exc_req), .exc_vec(exc_vec),
        .irq_req(irq_req), .irq_level(irq_level), .irq_auto(irq_auto), .irq_vec(irq_vec),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .init_sp(init_sp), .new_pc(new_pc), .done(done), .boot_flag(boot_flag),
        .svc_vec(svc_vec)
    );

    typedef struct packed {
        logic        berr;
        logic        aerr;
        logic        exc;
        logic [7:0]  ev;
        logic        irq;
        logic [2:0]  lvl;
        logic        au;
        logic [7:0]  iv;
        logic [31:0] vbr;
        logic [1:0]  w;
        logic [7:0]  xv;
    } tv_t;

    localparam int NTV = 9;
    localparam tv_t TBL [NTV] = '{
        '{1'b0, 1'b0, 1'b1, 8'd5,  1'b0, 3'd0, 1'b0, 8'd0,   32'h0000_0000, 2'd0, 8'd5},
        '{1'b1, 1'b1, 1'b1, 8'd4,  1'b1, 3'd5, 1'b1, 8'd0,   32'h0010_0000, 2'd1, 8'd2},
        '{1'b0, 1'b1, 1'b1, 8'd6,  1'b1, 3'd2, 1'b1, 8'd0,   32'h0010_0000, 2'd0, 8'd3},
        '{1'b0, 1'b0, 1'b1, 8'd9,  1'b1, 3'd7, 1'b1, 8'd0,   32'h0000_1000, 2'd2, 8'd9},
        '{1'b0, 1'b0, 1'b0, 8'd0,  1'b1, 3'd3, 1'b1, 8'd0,   32'h0010_0403, 2'd0, 8'd27},
        '{1'b0, 1'b0, 1'b0, 8'd0,  1'b1, 3'd7, 1'b1, 8'd77,  32'h0010_0400, 2'd3, 8'd31},
        '{1'b0, 1'b0, 1'b0, 8'd0,  1'b1, 3'd4, 1'b0, 8'd255, 32'hFFFF_FC00, 2'd1, 8'd255},
        '{1'b0, 1'b0, 1'b0, 8'd0,  1'b1, 3'd0, 1'b1, 8'd0,   32'h0000_0000, 2'd0, 8'd24},
        '{1'b0, 1'b0, 1'b1, 8'd47, 1'b0, 3'd0, 1'b0, 8'd0,   32'h0020_0002, 2'd0, 8'd47}
    };

    function automatic logic [15:0] memw(logic [31:0] a);
        return a[15:0] * 16'd3 + a[31:16] + 16'h1234;
    endfunction

    function automatic logic [31:0] meml(logic [31:0] a);
        return {memw(a), memw(a + 32'd2)};
    endfunction

    function automatic logic [31:0] vaddr(logic [31:0] base, logic [7:0] v);
        return {base[31:2], 2'b00} + {22'd0, v, 2'b00};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Serve one read expected at address a, with w extra wait cycles.
    // Starts and ends at a negative edge.
    task automatic do_read(input logic [31:0] a, input int w, input string tag);
        check(mem_rd === 1'b1, {tag, " R2 strobe"}, 32'(mem_rd), 32'd1);
        check(mem_addr === a, {tag, " R2 address"}, mem_addr, a);
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            check(mem_rd === 1'b1 && mem_addr === a, {tag, " R3 hold"}, mem_addr, a);
        end
        mem_rdy   = 1'b1;
        mem_rdata = memw(a);
        @(negedge clk);
        mem_rdy   = 1'b0;
        mem_rdata = 16'hDEAD;
    endtask

    task automatic fetch_vec(input logic [31:0] a, input int w, input logic [7:0] v,
                             input string tag);
        do_read(a, w, tag);
        do_read(a + 32'd2, 0, tag);
        check(done === 1'b1, {tag, " R8 done"}, 32'(done), 32'd1);
        check(new_pc === meml(a), {tag, " R4 handler"}, new_pc, meml(a));
        check(svc_vec === v, {tag, " R6 vector"}, 32'(svc_vec), 32'(v));
        check(boot_flag === 1'b0, {tag, " R8 flag"}, 32'(boot_flag), 32'd0);
        check(mem_rd === 1'b0, {tag, " R8 idle"}, 32'(mem_rd), 32'd0);
        @(negedge clk);
        check(done === 1'b0, {tag, " R8 pulse"}, 32'(done), 32'd0);
    endtask

    task automatic do_boot(input string tag);
        check(mem_rd === 1'b1 && mem_addr === 32'd0, {tag, " R1 start"}, mem_addr, 32'd0);
        check(done === 1'b0, {tag, " R1 no done"}, 32'(done), 32'd0);
        do_read(32'd0, 1, tag);
        do_read(32'd2, 0, tag);
        check(done === 1'b0, {tag, " R8 no early done"}, 32'(done), 32'd0);
        do_read(32'd4, 2, tag);
        do_read(32'd6, 0, tag);
        check(done === 1'b1, {tag, " R1 done"}, 32'(done), 32'd1);
        check(init_sp === meml(32'd0), {tag, " R1 sp"}, init_sp, meml(32'd0));
        check(new_pc === meml(32'd4), {tag, " R1 pc"}, new_pc, meml(32'd4));
        check(boot_flag === 1'b1, {tag, " R1 flag"}, 32'(boot_flag), 32'd1);
        check(svc_vec === 8'd0, {tag, " R1 vec"}, 32'(svc_vec), 32'd0);
        @(negedge clk);
        check(done === 1'b0, {tag, " R8 pulse"}, 32'(done), 32'd0);
    endtask

    task automatic clear_reqs();
        berr_req = 1'b0; aerr_req = 1'b0; exc_req = 1'b0; irq_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0 && mem_addr === 32'd0, "R1 in reset", mem_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        do_boot("boot");
        boot_sp = init_sp;

        // R9: mem_rdy while idle must not start anything
        mem_rdy = 1'b1;
        @(negedge clk);
        mem_rdy = 1'b0;
        check(mem_rd === 1'b0 && done === 1'b0, "R9 idle rdy", 32'(mem_rd), 32'd0);

        // Table walk: R4 R5 R6 R7
        for (int i = 0; i < NTV; i++) begin
            vbr_we = 1'b1; vbr_wdata = TBL[i].vbr;
            @(negedge clk);
            vbr_we = 1'b0;
            berr_req = TBL[i].berr; aerr_req = TBL[i].aerr;
            exc_req = TBL[i].exc;   exc_vec = TBL[i].ev;
            irq_req = TBL[i].irq;   irq_level = TBL[i].lvl;
            irq_auto = TBL[i].au;   irq_vec = TBL[i].iv;
            @(negedge clk);
            clear_reqs();
            fetch_vec(vaddr(TBL[i].vbr, TBL[i].xv), int'(TBL[i].w), TBL[i].xv,
                      $sformatf("tbl%0d R7", i));
            check(init_sp === boot_sp, "R10 sp kept", init_sp, boot_sp);
        end

        // R5: base written in the same cycle as an accepted request
        vbr_we = 1'b1; vbr_wdata = 32'h0000_2000;
        @(negedge clk);
        vbr_we = 1'b1; vbr_wdata = 32'h0030_0000;
        exc_req = 1'b1; exc_vec = 8'd10;
        @(negedge clk);
        vbr_we = 1'b0; clear_reqs();
        fetch_vec(32'h0000_2000 + 32'd40, 0, 8'd10, "same-cycle R5 old base");
        exc_req = 1'b1; exc_vec = 8'd11;
        @(negedge clk);
        clear_reqs();
        fetch_vec(32'h0030_0000 + 32'd44, 0, 8'd11, "after-write R5 new base");

        // R9: bus error raised mid-fetch is held off, then served
        vbr_wdata = 32'h0;
        exc_req = 1'b1; exc_vec = 8'd5;
        @(negedge clk);
        clear_reqs();
        berr_req = 1'b1;
        fetch_vec(32'h0030_0000 + 32'd20, 2, 8'd5, "busy R9");
        berr_req = 1'b0;
        fetch_vec(32'h0030_0000 + 32'd8, 0, 8'd2, "held R9");
        check(init_sp === boot_sp, "R10 sp kept", init_sp, boot_sp);

        // Reset partway through a fetch: boot reruns, base back to zero (R5)
        exc_req = 1'b1; exc_vec = 8'd6;
        @(negedge clk);
        clear_reqs();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_boot("reboot");
        exc_req = 1'b1; exc_vec = 8'd11;
        @(negedge clk);
        clear_reqs();
        fetch_vec(32'd44, 1, 8'd11, "reset base R5");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule